// File: doc/BRIEF.md
# Operand Forwarding Select

This block decides, for each of the two ALU operands of the instruction sitting in the execute stage of a five-stage in-order pipeline, where that operand's value should come from. It looks at the two source register numbers of the execute-stage instruction. It also looks at the destination register number and register-write flag of the two older instructions: the one that has just left execute (the memory-stage latch) and the one that is about to write back (the writeback-stage latch). For each operand it produces a 2-bit select for the operand multiplexer in front of the ALU.

The logic is purely combinational. The selects follow the pipeline latches within the same cycle, so the datapath can use them in the cycle in which the latches present the register numbers. The two operands are resolved independently. When both older instructions target the same register, the younger one wins, so a chain of updates to one register always delivers its latest value. Register zero reads as a constant and is never a forwarding target. A library parameter can turn that exclusion off for register files without a hardwired zero register.

Top module: `fwd_unit`

## Requirements
- R1: While the pipeline latches hold their cleared state (all write flags low), both selects are 2'b00.
- R2: An operand's select is 2'b10 when the memory-stage latch has its write flag set, a nonzero destination, and a destination equal to that operand's source register number.
- R3: An operand's select is 2'b01 when the writeback-stage latch has its write flag set, a nonzero destination equal to the operand's source, and the R2 condition for that operand is false.
- R4: When both latches match an operand, the select is 2'b10. In a run of three consecutive instructions that each write the same register and read it, the third sees 2'b10.
- R5: A latch with its write flag low never causes forwarding, whatever its destination number.
- R6: A destination of register 0 never causes forwarding (with the default setting ZERO_HARDWIRED=1).
- R7: Operand A (compared against the rs field) and operand B (compared against the rt field) are resolved separately, so in one cycle A may select 2'b10 while B selects 2'b01.
- R8: When no latch qualifies, the select is 2'b00, the register-file read value.
- R9: The value 2'b11 is never produced on either select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ex_rs_num | input | REG_W | First source register number of the execute-stage instruction |
| ex_rt_num | input | REG_W | Second source register number of the execute-stage instruction |
| mem_dst_num | input | REG_W | Destination register number held in the memory-stage latch |
| mem_wr_en | input | 1 | Register-write flag held in the memory-stage latch |
| wb_dst_num | input | REG_W | Destination register number held in the writeback-stage latch |
| wb_wr_en | input | 1 | Register-write flag held in the writeback-stage latch |
| fwd_sel_a | output | 2 | Operand A source select: 00 register file, 01 writeback latch, 10 memory latch |
| fwd_sel_b | output | 2 | Operand B source select, same encoding |

## Verification
The bench builds the block with its defaults: 5-bit register numbers and the register-zero exclusion enabled. These cover the zero-destination case and full 32-entry register numbering. A mock pipeline in the bench shifts destination and write flags from stage to stage, and the random phase draws register numbers from only 0 to 7. This makes collisions between the two older instructions, double hits, and zero destinations frequent rather than rare.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

   // Operand source encodings seen by the ALU input multiplexer
   typedef enum logic [1:0] {
      SEL_REGFILE = 2'b00,
      SEL_WB      = 2'b01,
      SEL_MEM     = 2'b10
   } fwd_sel_e;

   // Number of ALU operands resolved by the unit
   localparam int unsigned NUM_OPND = 2;

endpackage

// File: rtl/fwd_stage_hit.sv
module fwd_stage_hit #(
   parameter int unsigned REG_W          = 5,
   parameter bit          ZERO_HARDWIRED = 1'b1
) (
   input  logic             wr_en,
   input  logic [REG_W-1:0] dst_num,
   input  logic [REG_W-1:0] src_num,
   output logic             hit
);

   logic dst_ok;
   logic num_eq;

   // Variant: exclude register zero only when it is a constant register
   generate
      if (ZERO_HARDWIRED) begin : g_zero_filter
         assign dst_ok = |dst_num;
      end else begin : g_no_filter
         assign dst_ok = 1'b1;
      end
   endgenerate

   assign num_eq = (dst_num == src_num);
   assign hit    = wr_en & dst_ok & num_eq;

endmodule

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel
   import fwd_pkg::*;
#(
   parameter int unsigned REG_W          = 5,
   parameter bit          ZERO_HARDWIRED = 1'b1
) (
   input  logic [REG_W-1:0] src_num,
   input  logic             mem_wr_en,
   input  logic [REG_W-1:0] mem_dst_num,
   input  logic             wb_wr_en,
   input  logic [REG_W-1:0] wb_dst_num,
   output fwd_sel_e         sel
);

   logic mem_hit;
   logic wb_hit;

   fwd_stage_hit #(
      .REG_W          (REG_W),
      .ZERO_HARDWIRED (ZERO_HARDWIRED)
   ) i_mem_hit (
      .wr_en   (mem_wr_en),
      .dst_num (mem_dst_num),
      .src_num (src_num),
      .hit     (mem_hit)
   );

   fwd_stage_hit #(
      .REG_W          (REG_W),
      .ZERO_HARDWIRED (ZERO_HARDWIRED)
   ) i_wb_hit (
      .wr_en   (wb_wr_en),
      .dst_num (wb_dst_num),
      .src_num (src_num),
      .hit     (wb_hit)
   );

   // Younger result wins; older one only when the younger misses
   always_comb begin
      if (mem_hit) begin
         sel = SEL_MEM;
      end else if (wb_hit) begin
         sel = SEL_WB;
      end else begin
         sel = SEL_REGFILE;
      end
   end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
   import fwd_pkg::*;
#(
   parameter int unsigned REG_W          = 5,
   parameter bit          ZERO_HARDWIRED = 1'b1
) (
   input  logic [REG_W-1:0] ex_rs_num,
   input  logic [REG_W-1:0] ex_rt_num,
   input  logic [REG_W-1:0] mem_dst_num,
   input  logic             mem_wr_en,
   input  logic [REG_W-1:0] wb_dst_num,
   input  logic             wb_wr_en,
   output logic [1:0]       fwd_sel_a,
   output logic [1:0]       fwd_sel_b
);

   localparam int unsigned OPND_IDX_A = 0;
   localparam int unsigned OPND_IDX_B = 1;

   // Elaboration-time parameter checks
   generate
      if (REG_W < 1 || REG_W > 16) begin : g_bad_reg_w
         $error("fwd_unit: REG_W out of supported range");
      end
   endgenerate

   logic [REG_W-1:0] src_num [NUM_OPND];
   fwd_sel_e         sel     [NUM_OPND];

   assign src_num[OPND_IDX_A] = ex_rs_num;
   assign src_num[OPND_IDX_B] = ex_rt_num;

   generate
      for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
         fwd_operand_sel #(
            .REG_W          (REG_W),
            .ZERO_HARDWIRED (ZERO_HARDWIRED)
         ) i_opnd (
            .src_num     (src_num[g]),
            .mem_wr_en   (mem_wr_en),
            .mem_dst_num (mem_dst_num),
            .wb_wr_en    (wb_wr_en),
            .wb_dst_num  (wb_dst_num),
            .sel         (sel[g])
         );
      end
   endgenerate

   assign fwd_sel_a = sel[OPND_IDX_A];
   assign fwd_sel_b = sel[OPND_IDX_B];

endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
   parameter int unsigned REG_W          = 5,
   parameter bit          ZERO_HARDWIRED = 1'b1
) (
   input logic [REG_W-1:0] ex_rs_num,
   input logic [REG_W-1:0] ex_rt_num,
   input logic [REG_W-1:0] mem_dst_num,
   input logic             mem_wr_en,
   input logic [REG_W-1:0] wb_dst_num,
   input logic             wb_wr_en,
   input logic [1:0]       fwd_sel_a,
   input logic [1:0]       fwd_sel_b
);

   logic zero_ok_mem;
   logic zero_ok_wb;
   assign zero_ok_mem = !ZERO_HARDWIRED || (mem_dst_num != '0);
   assign zero_ok_wb  = !ZERO_HARDWIRED || (wb_dst_num != '0);

   always_comb begin
      assert_sel_legal_R9: assert (fwd_sel_a != 2'b11 && fwd_sel_b != 2'b11)
         else $error("select took the unused code");

      // R5: no write flags, no forwarding on either operand
      assert_idle_R5: assert ((mem_wr_en || wb_wr_en) || (fwd_sel_a == 2'b00 && fwd_sel_b == 2'b00))
         else $error("forwarding without a writing stage");

      // R2 / R4: a qualified younger match always wins
      assert_mem_pick_R2: assert (!(mem_wr_en && zero_ok_mem && mem_dst_num == ex_rs_num) || fwd_sel_a == 2'b10)
         else $error("operand A missed memory-stage forward");

      // R3: older match only when the younger one does not qualify
      assert_wb_pick_R3: assert (fwd_sel_b != 2'b01 ||
                                 (wb_wr_en && zero_ok_wb && wb_dst_num == ex_rt_num &&
                                  !(mem_wr_en && zero_ok_mem && mem_dst_num == ex_rt_num)))
         else $error("operand B took writeback path without cause");

      // R6: register zero never forwarded
      assert_zero_block_R6: assert (!ZERO_HARDWIRED || ex_rs_num != '0 || fwd_sel_a == 2'b00)
         else $error("register zero forwarded on operand A");
   end

endmodule

bind fwd_unit fwd_unit_chk #(
   .REG_W          (REG_W),
   .ZERO_HARDWIRED (ZERO_HARDWIRED)
) i_fwd_unit_chk (
   .ex_rs_num   (ex_rs_num),
   .ex_rt_num   (ex_rt_num),
   .mem_dst_num (mem_dst_num),
   .mem_wr_en   (mem_wr_en),
   .wb_dst_num  (wb_dst_num),
   .wb_wr_en    (wb_wr_en),
   .fwd_sel_a   (fwd_sel_a),
   .fwd_sel_b   (fwd_sel_b)
);

// File: tb/test_fwd_unit.sv
`timescale 1ns/1ps
module test_fwd_unit;

   typedef struct {
      logic [4:0] rd;
      logic [4:0] rs;
      logic [4:0] rt;
      logic       wr;
   } instr_t;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #5 clk = ~clk;

   // Next instruction entering execute
   logic [4:0] nxt_rd = '0, nxt_rs = '0, nxt_rt = '0;
   logic       nxt_wr = 1'b0;

   // Mock pipeline latches
   logic [4:0] ex_rs, ex_rt, ex_rd, mem_rd, wb_rd;
   logic       ex_wr, mem_wr, wb_wr;
   logic [1:0] sel_a, sel_b;

   always_ff @(posedge clk) begin
      if (rst) begin
         ex_rs <= '0; ex_rt <= '0; ex_rd <= '0; ex_wr <= 1'b0;
         mem_rd <= '0; mem_wr <= 1'b0; wb_rd <= '0; wb_wr <= 1'b0;
      end else begin
         ex_rs <= nxt_rs; ex_rt <= nxt_rt; ex_rd <= nxt_rd; ex_wr <= nxt_wr;
         mem_rd <= ex_rd; mem_wr <= ex_wr;
         wb_rd <= mem_rd; wb_wr <= mem_wr;
      end
   end

   fwd_unit i_fwd_unit (
      .ex_rs_num   (ex_rs),
      .ex_rt_num   (ex_rt),
      .mem_dst_num (mem_rd),
      .mem_wr_en   (mem_wr),
      .wb_dst_num  (wb_rd),
      .wb_wr_en    (wb_wr),
      .fwd_sel_a   (sel_a),
      .fwd_sel_b   (sel_b)
   );

   int     total = 0;
   int     bad = 0;
   bit     done = 1'b0;
   instr_t hist[$];

   // Reference: scan older instructions youngest first, first writer wins
   function automatic logic [1:0] ref_sel(logic [4:0] src);
      int n = hist.size();
      for (int age = 1; age <= 2; age++) begin
         if (n > age) begin
            instr_t e = hist[n - 1 - age];
            if (e.wr && e.rd != 5'd0 && e.rd == src)
               return (age == 1) ? 2'b10 : 2'b01;
         end
      end
      return 2'b00;
   endfunction

   task automatic check(string tag, string what, logic [1:0] act, logic [1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
      end
   endtask

   task automatic step(logic [4:0] rd, logic [4:0] rs, logic [4:0] rt, logic wr, string tag);
      instr_t e;
      nxt_rd = rd; nxt_rs = rs; nxt_rt = rt; nxt_wr = wr;
      @(posedge clk);
      e.rd = rd; e.rs = rs; e.rt = rt; e.wr = wr;
      hist.push_back(e);
      if (hist.size() > 4) void'(hist.pop_front());
      @(negedge clk);
      check(tag, "sel_a", sel_a, ref_sel(rs));
      check(tag, "sel_b", sel_b, ref_sel(rt));
   endtask

   initial begin
      nxt_rd = 5'd9; nxt_rs = 5'd9; nxt_rt = 5'd9; nxt_wr = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1", "reset sel_a", sel_a, 2'b00);
      check("R1", "reset sel_b", sel_b, 2'b00);
      rst = 1'b0;

      // R8 then R2 then R3: producer followed by two consumers
      step(5'd2, 5'd1, 5'd3, 1'b1, "R8");
      step(5'd12, 5'd2, 5'd5, 1'b1, "R2");
      step(5'd13, 5'd6, 5'd2, 1'b1, "R3");
      step(5'd14, 5'd20, 5'd21, 1'b1, "R8");

      // R4: three updates of the same register
      step(5'd1, 5'd1, 5'd2, 1'b1, "R4");
      step(5'd1, 5'd1, 5'd3, 1'b1, "R4");
      step(5'd1, 5'd1, 5'd4, 1'b1, "R4");

      // R5: matching destination but no write
      step(5'd7, 5'd0, 5'd0, 1'b0, "R5");
      step(5'd8, 5'd7, 5'd7, 1'b1, "R5");
      step(5'd0, 5'd7, 5'd7, 1'b0, "R5");

      // R6: writes to register zero
      step(5'd0, 5'd1, 5'd1, 1'b1, "R6");
      step(5'd0, 5'd0, 5'd0, 1'b1, "R6");
      step(5'd3, 5'd0, 5'd0, 1'b1, "R6");

      // R7: operands from different stages in one cycle
      step(5'd8, 5'd1, 5'd1, 1'b1, "R7");
      step(5'd9, 5'd1, 5'd1, 1'b1, "R7");
      step(5'd10, 5'd9, 5'd8, 1'b1, "R7");
      step(5'd11, 5'd10, 5'd9, 1'b1, "R7");

      // Random replay over a small register range (R2 R3 R4 R5 R6 R8)
      for (int i = 0; i < 400; i++) begin
         step(5'($urandom_range(0, 7)), 5'($urandom_range(0, 7)),
              5'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), "R2_R3_rand");
      end

      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule